// File: doc/BRIEF.md
# Dual-Path Carry Adder

This block adds two unsigned N-bit operands and a carry input. It computes the result twice, side by side, from one shared front end. In the front end, each bit position produces a half-sum (the exclusive OR of the two operand bits), a generate term (their AND) and a propagate term (their inclusive OR). The first carry path chains these terms from bit to bit. The second path builds every carry directly from the generate and propagate terms of the lower bits and the carry input, so no carry waits for another carry. Each path then finishes its own sum with a second exclusive-OR stage.

Both sums and both final carries leave the block, together with a flag that rises whenever the two paths disagree. The block has no clock and no state. The chained path acts as a reference in silicon, and the flag lets surrounding logic or a test harness catch a defect in the faster network at any moment. The width is a parameter, with a default of 4 and support up to 8.

Top module: `dual_path_adder`

## Requirements
- R1: For every input combination, both `sum_ripple` and `sum_ahead` equal the low N bits of a_in + b_in + carry_in, where bit 0 is the least significant bit.
- R2: For every input combination, both `cout_ripple` and `cout_ahead` equal bit N of a_in + b_in + carry_in.
- R3: The carry input is a full operand. With a_in all ones, b_in zero and carry_in 1, the carry travels across every bit: both sums are zero and both carry-outs are 1.
- R4: `paths_differ` is 0 for all 2^(2N+1) input combinations.
- R5: Propagate is the inclusive OR of the operand bits. When both operand bits of a position are 1, that position generates and also propagates. With a_in equal to b_in, the result equals twice the operand plus carry_in.
- R6: Bit 0 of `sum_ahead` is a_in[0] XOR b_in[0] XOR carry_in. It depends on no other operand bit.
- R7: At every bit position, the carry of the lookahead network equals the carry of the chained path, so the two sums are always identical.
- R8: With both operands zero, both sums equal carry_in in bit 0 with every other bit zero, and both carry-outs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_ripple | output | N | Sum from the chained carry path |
| cout_ripple | output | 1 | Final carry from the chained path |
| sum_ahead | output | N | Sum from the lookahead carry path |
| cout_ahead | output | 1 | Final carry from the lookahead network |
| paths_differ | output | 1 | High when the sums or the final carries of the two paths differ |

## Verification
The bench builds two copies of the block: one with the default width of 4 and one with a width of 6. For each copy it sweeps every combination of operands and carry input, which is 512 and 8192 cases. At width 4 the directed corner cases also run: a carry travelling across all bits, equal operands, a zero operand, and checks on bit 0 alone. The width-6 copy reaches product terms up to seven factors deep, so any indexing slip in the lookahead loops that the shallow default would hide shows up there.

// File: rtl/adder_pkg.sv
package adder_pkg;
  localparam int unsigned WIDTH_MAX = 8;

  // AND of v[lo..hi]; an empty span (lo > hi) yields 1.
  function automatic logic span_and(input logic [WIDTH_MAX-1:0] v,
                                    input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < WIDTH_MAX; k++) begin
      if (k >= lo && k <= hi) r = r & v[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/gp_stage.sv
module gp_stage #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic [N-1:0] half_sum,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign half_sum[i] = a_in[i] ^ b_in[i];
    assign gen[i]      = a_in[i] & b_in[i];
    assign prop[i]     = a_in[i] | b_in[i];

    always_comb begin
      if (!$isunknown({gen[i], prop[i], half_sum[i]})) begin
        // R5: generating position must also propagate (inclusive OR)
        a_r5_gen_implies_prop: assert (!gen[i] || prop[i]);
        // R5: half-sum and generate are never both set
        a_r5_hsum_gen_exclusive: assert (!(gen[i] && half_sum[i]));
      end
    end
  end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         carry_in,
  output logic [N:0]   carry
);
  assign carry[0] = carry_in;
  for (genvar i = 0; i < N; i++) begin : g_link
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end
endmodule

// File: rtl/lookahead_net.sv
module lookahead_net
  import adder_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         carry_in,
  output logic [N:0]   carry
);
  localparam int unsigned PAD = WIDTH_MAX - N;

  logic [WIDTH_MAX-1:0] prop_w;
  logic [WIDTH_MAX-1:0] gen_w;
  assign prop_w = {{PAD{1'b0}}, prop};
  assign gen_w  = {{PAD{1'b0}}, gen};

  assign carry[0] = carry_in;

  // Carry i: sum of products over lower generate/propagate terms and carry_in.
  for (genvar i = 1; i <= N; i++) begin : g_carry
    logic acc;
    always_comb begin
      acc = carry_in & span_and(prop_w, 0, i - 1);
      for (int j = 0; j < i; j++) begin
        acc = acc | (gen_w[j] & span_and(prop_w, j + 1, i - 1));
      end
    end
    assign carry[i] = acc;
  end
endmodule

// File: rtl/sum_stage.sv
module sum_stage #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] half_sum,
  input  logic [N-1:0] carry,
  output logic [N-1:0] sum
);
  for (genvar i = 0; i < N; i++) begin : g_xor
    assign sum[i] = half_sum[i] ^ carry[i];
  end
endmodule

// File: rtl/dual_path_adder.sv
module dual_path_adder #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         carry_in,
  output logic [N-1:0] sum_ripple,
  output logic         cout_ripple,
  output logic [N-1:0] sum_ahead,
  output logic         cout_ahead,
  output logic         paths_differ
);
  logic [N-1:0] half_sum, gen, prop;
  logic [N:0]   c_rip, c_la;

  gp_stage #(.N(N)) u_gp (
    .a_in(a_in), .b_in(b_in),
    .half_sum(half_sum), .gen(gen), .prop(prop)
  );

  ripple_chain #(.N(N)) u_rip (
    .gen(gen), .prop(prop), .carry_in(carry_in), .carry(c_rip)
  );

  lookahead_net #(.N(N)) u_la (
    .gen(gen), .prop(prop), .carry_in(carry_in), .carry(c_la)
  );

  sum_stage #(.N(N)) u_sum_rip (
    .half_sum(half_sum), .carry(c_rip[N-1:0]), .sum(sum_ripple)
  );

  // Bit 0 takes carry_in directly since c_la[0] is carry_in.
  sum_stage #(.N(N)) u_sum_la (
    .half_sum(half_sum), .carry(c_la[N-1:0]), .sum(sum_ahead)
  );

  assign cout_ripple  = c_rip[N];
  assign cout_ahead   = c_la[N];
  assign paths_differ = (sum_ripple != sum_ahead) | (cout_ripple != cout_ahead);

  logic [N:0] ref_total;
  assign ref_total = {1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, carry_in};

  always_comb begin
    if (!$isunknown({a_in, b_in, carry_in})) begin
      // R7: every lookahead carry equals the chained carry
      a_r7_carries_agree: assert (c_la == c_rip);
      // R1 R2: lookahead result matches the arithmetic sum
      a_r1_ahead_arith: assert ({cout_ahead, sum_ahead} == ref_total);
      // R1 R2: chained result matches the arithmetic sum
      a_r2_ripple_arith: assert ({cout_ripple, sum_ripple} == ref_total);
      // R4: the two paths never disagree
      a_r4_no_disagree: assert (!paths_differ);
      // R6: bit 0 of the lookahead sum uses carry_in directly
      a_r6_bit0_direct: assert (sum_ahead[0] == (a_in[0] ^ b_in[0] ^ carry_in));
    end
  end
endmodule

// File: tb/tb_dual_path_adder.sv
`timescale 1ns/1ps
module tb_dual_path_adder;
  localparam int unsigned NA = 4;
  localparam int unsigned NB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NA-1:0] a4, b4, s4r, s4a;
  logic          c4, co4r, co4a, d4;
  logic [NB-1:0] a6, b6, s6r, s6a;
  logic          c6, co6r, co6a, d6;

  dual_path_adder #(.N(NA)) dut (
    .a_in(a4), .b_in(b4), .carry_in(c4),
    .sum_ripple(s4r), .cout_ripple(co4r),
    .sum_ahead(s4a), .cout_ahead(co4a), .paths_differ(d4)
  );

  dual_path_adder #(.N(NB)) dut_w6 (
    .a_in(a6), .b_in(b6), .carry_in(c6),
    .sum_ripple(s6r), .cout_ripple(co6r),
    .sum_ahead(s6a), .cout_ahead(co6a), .paths_differ(d6)
  );

  typedef struct packed {
    logic [7:0] sum;
    logic       cout;
  } exp_t;

  exp_t q4[$];
  exp_t q6[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver tasks: apply a vector and push the expected result.
  task automatic drive4(input int va, input int vb, input int vc);
    exp_t e;
    int t;
    @(posedge clk);
    a4 = NA'(va); b4 = NA'(vb); c4 = vc[0];
    t = va + vb + vc;
    e.sum = 8'(t % (1 << NA));
    e.cout = (t >> NA) & 1;
    q4.push_back(e);
  endtask

  task automatic drive6(input int va, input int vb, input int vc);
    exp_t e;
    int t;
    @(posedge clk);
    a6 = NB'(va); b6 = NB'(vb); c6 = vc[0];
    t = va + vb + vc;
    e.sum = 8'(t % (1 << NB));
    e.cout = (t >> NB) & 1;
    q6.push_back(e);
  endtask

  // Monitor: pop and compare at the falling edge.
  always @(negedge clk) begin
    if (q4.size() > 0) begin
      exp_t e;
      e = q4.pop_front();
      chk("R1 ripple sum w4", 9'(s4r), 9'(e.sum));
      chk("R1 ahead sum w4", 9'(s4a), 9'(e.sum));
      chk("R2 couts w4", {7'b0, co4r, co4a}, {7'b0, e.cout, e.cout});
      chk("R4 differ w4", 9'(d4), 9'd0);
      chk("R7 sums equal w4", 9'(s4a), 9'(s4r));
    end
    if (q6.size() > 0) begin
      exp_t e;
      e = q6.pop_front();
      chk("R1 ripple sum w6", 9'(s6r), 9'(e.sum));
      chk("R1 ahead sum w6", 9'(s6a), 9'(e.sum));
      chk("R2 couts w6", {7'b0, co6r, co6a}, {7'b0, e.cout, e.cout});
      chk("R4 differ w6", 9'(d6), 9'd0);
      chk("R7 sums equal w6", 9'(s6a), 9'(s6r));
    end
  end

  // Directed check on the width-4 copy, applied at posedge, sampled at negedge.
  task automatic direct4(input string req, input int va, input int vb, input int vc,
                         input int exp_sum, input int exp_cout);
    @(posedge clk);
    a4 = NA'(va); b4 = NA'(vb); c4 = vc[0];
    @(negedge clk);
    chk(req, 9'(s4r), 9'(exp_sum));
    chk(req, 9'(s4a), 9'(exp_sum));
    chk(req, {7'b0, co4r, co4a}, {7'b0, 1'(exp_cout), 1'(exp_cout)});
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    a4 = '0; b4 = '0; c4 = 1'b0;
    a6 = '0; b6 = '0; c6 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: zero operands during reset give zero outputs
    chk("R8 reset state w4", {s4r, s4a, d4}, 9'd0);
    chk("R8 reset state w6", {co6r, co6a, s6a}, 9'd0);
    rst = 1'b0;

    // R3: carry crosses every bit
    direct4("R3 full carry chain", 15, 0, 1, 0, 1);
    direct4("R3 full carry both ones", 15, 15, 1, 15, 1);
    // R5: equal operands, every set position generates and propagates
    direct4("R5 equal operands 5", 5, 5, 1, 11, 0);
    direct4("R5 equal operands 9", 9, 9, 0, 2, 1);
    // R8: zero operands pass carry_in through
    direct4("R8 zero operands cin1", 0, 0, 1, 1, 0);
    direct4("R8 zero operands cin0", 0, 0, 0, 0, 0);
    // R6: bit 0 of lookahead sum independent of upper bits
    @(posedge clk); a4 = 4'h6; b4 = 4'h9; c4 = 1'b1;
    @(negedge clk); chk("R6 bit0 a6 b9 c1", 9'(s4a[0]), 9'd0);
    @(posedge clk); a4 = 4'hE; b4 = 4'h0; c4 = 1'b1;
    @(negedge clk); chk("R6 bit0 aE b0 c1", 9'(s4a[0]), 9'd1);

    // Exhaustive sweeps (R1 R2 R4 R7)
    for (int va = 0; va < (1 << NA); va++)
      for (int vb = 0; vb < (1 << NA); vb++)
        for (int vc = 0; vc < 2; vc++)
          drive4(va, vb, vc);
    for (int va = 0; va < (1 << NB); va++)
      for (int vb = 0; vb < (1 << NB); vb++)
        for (int vc = 0; vc < 2; vc++)
          drive6(va, vb, vc);

    repeat (3) @(posedge clk);
    wrap_up();
  end
endmodule